// File: doc/BRIEF.md
# Double-Data-Rate Command/Address Bus Decoder

This block is a passive monitor for the 10-bit command/address bus of a low-power SDRAM. It is tapped in parallel with the memory device. It samples the bus once on the rising edge of the memory clock and once on the falling edge. It joins the two halves into one command for that clock cycle. The command is classified, and the address fields that the command carries are extracted into held output registers. Fields that the command does not carry keep their last values.

The bus half seen at the rising edge is stored in a register. At the falling edge, the stored half and the live bus are decoded together, and the results are registered. A test environment can therefore read the command and its fields from the falling edge onward. Only the SDRAM command set is covered. Power states based on chip select or clock enable, and any timing-rule checks, are left to other logic.

Top module: `ddr_ca_decoder`

## Requirements
- R1: An active-low asynchronous reset forces cmd_o to NOP (code 0) and clears every held field to zero at once, without waiting for a clock edge. After reset, the stored rising half reads as all ones, which decodes as NOP.
- R2: The rising half is captured on the rising clock edge and the falling half on the falling edge. cmd_o and the fields change only at the falling edge that completes the cycle, so they keep their old values while the falling half is already on the bus.
- R3: The command is decoded from rising-half bits 0 to 3. Bits 1:0 = 10 gives ACT (1). Bits 1:0 = 01 gives WR (2) when bit 2 is 0 and RD (3) when bit 2 is 1. Bits 2:0 = 011 gives BST (5) when bit 3 is 0 and PRE (4) when bit 3 is 1. Bits 2:0 = 111 gives NOP (0).
- R4: Bits 1:0 = 00 select the mode-register/refresh group, which bits 3:2 split further: 00 gives MRW (6), 01 gives MRR (7), 10 gives per-bank refresh (8) and 11 gives all-bank refresh (9).
- R5: bank_o takes rising-half bits 9:7 on ACT, WR, RD and PRE. It holds its value on every other command.
- R6: row_o takes the 10 falling-half bits as its upper part and rising-half bits 6:2 as its lower 5 bits, on ACT only.
- R7: On WR and RD only, col_o takes falling-half bits 9:1 as its upper part and rising-half bits 6:4 as its lower 3 bits, and ap_o takes falling-half bit 0.
- R8: On MRW and MRR only, mr_addr_o takes rising-half bits 9:4 as its upper part and falling-half bits 1:0 as its lower 2 bits, and mr_data_o takes falling-half bits 9:2.
- R9: NOP, BST and both refresh commands update cmd_o but leave every address field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock, shared with the monitored device |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ca_i | input | 10 | Command/address bus, sampled on both clock edges |
| cmd_o | output | 4 | Decoded command code of the current cycle |
| bank_o | output | 3 | Held bank address |
| row_o | output | 15 | Held row address |
| col_o | output | 12 | Held column address |
| ap_o | output | 1 | Held auto-precharge flag |
| mr_addr_o | output | 8 | Held mode-register address |
| mr_data_o | output | 8 | Held mode-register operand |

## Verification
Every result of a cycle is due at the falling edge of that same cycle, half a clock after the rising half is stored and with no further delay. The bench places the rising half before the rising edge and the falling half just after it. It then checks once between the falling half's arrival and the falling edge, where the old values must still stand. It checks again 1 ns after the falling edge, where the behavioural model's new values must appear. Reset is checked between edges, so the asynchronous clear is seen without any clock.

// File: rtl/ddr_ca_pkg.sv
`timescale 1ns/1ps
package ddr_ca_pkg;
  localparam int CA_W     = 10;
  localparam int BANK_W   = 3;
  localparam int BANK_LSB = CA_W - BANK_W;
  localparam int ROW_LO_W = BANK_LSB - 2;
  localparam int ROW_W    = CA_W + ROW_LO_W;
  localparam int COL_LO_W = BANK_LSB - 4;
  localparam int COL_W    = CA_W - 1 + COL_LO_W;
  localparam int MR_W     = CA_W - 2;
  localparam int MRA_HI_W = CA_W - 4;
  localparam int MRA_LO_W = MR_W - MRA_HI_W;
  localparam int CMD_W    = 4;

  typedef logic [CA_W-1:0] ca_t;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP   = 4'd0,
    CMD_ACT   = 4'd1,
    CMD_WR    = 4'd2,
    CMD_RD    = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_BST   = 4'd5,
    CMD_MRW   = 4'd6,
    CMD_MRR   = 4'd7,
    CMD_REFPB = 4'd8,
    CMD_REFAB = 4'd9
  } cmd_e;

  function automatic cmd_e decode_cmd(ca_t r);
    cmd_e c;
    unique casez (r[3:0])
      4'b??00: begin
        case (r[3:2])
          2'b00:   c = CMD_MRW;
          2'b01:   c = CMD_MRR;
          2'b10:   c = CMD_REFPB;
          default: c = CMD_REFAB;
        endcase
      end
      4'b??10: c = CMD_ACT;
      4'b?001: c = CMD_WR;
      4'b?101: c = CMD_RD;
      4'b0011: c = CMD_BST;
      4'b1011: c = CMD_PRE;
      default: c = CMD_NOP;
    endcase
    return c;
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(ca_t r);
    return r[CA_W-1:BANK_LSB];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(ca_t r, ca_t f);
    return {f, r[BANK_LSB-1:2]};
  endfunction

  function automatic logic [COL_W-1:0] col_of(ca_t r, ca_t f);
    return {f[CA_W-1:1], r[BANK_LSB-1:4]};
  endfunction

  function automatic logic [MR_W-1:0] mra_of(ca_t r, ca_t f);
    return {r[CA_W-1:4], f[MRA_LO_W-1:0]};
  endfunction

  function automatic logic [MR_W-1:0] mrd_of(ca_t f);
    return f[CA_W-1:2];
  endfunction
endpackage

// File: rtl/ddr_ca_rise_cap.sv
`timescale 1ns/1ps
module ddr_ca_rise_cap
  import ddr_ca_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ca_t  ca_i,
  output ca_t  rise_o
);
  // Reset value of all ones decodes as NOP.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_o <= '1;
    else         rise_o <= ca_i;
  end
endmodule

// File: rtl/ddr_ca_classify.sv
`timescale 1ns/1ps
module ddr_ca_classify
  import ddr_ca_pkg::*;
(
  input  ca_t               rise_i,
  input  ca_t               fall_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              upd_bank_o,
  output logic              upd_row_o,
  output logic              upd_col_o,
  output logic              upd_mr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W:0]    col_ap_o,
  output logic [2*MR_W-1:0] mr_o
);
  cmd_e cmd;

  always_comb begin
    cmd        = decode_cmd(rise_i);
    cmd_o      = cmd;
    upd_row_o  = (cmd == CMD_ACT);
    upd_col_o  = (cmd == CMD_WR) || (cmd == CMD_RD);
    upd_mr_o   = (cmd == CMD_MRW) || (cmd == CMD_MRR);
    upd_bank_o = upd_row_o || upd_col_o || (cmd == CMD_PRE);
    bank_o     = bank_of(rise_i);
    row_o      = row_of(rise_i, fall_i);
    col_ap_o   = {col_of(rise_i, fall_i), fall_i[0]};
    mr_o       = {mra_of(rise_i, fall_i), mrd_of(fall_i)};
  end
endmodule

// File: rtl/ddr_ca_field_reg.sv
`timescale 1ns/1ps
module ddr_ca_field_reg #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/ddr_ca_decoder.sv
`timescale 1ns/1ps
module ddr_ca_decoder
  import ddr_ca_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CA_W-1:0]   ca_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o,
  output logic [MR_W-1:0]   mr_addr_o,
  output logic [MR_W-1:0]   mr_data_o
);
  ca_t               rise_q;
  logic [CMD_W-1:0]  cmd_next;
  logic              upd_bank, upd_row, upd_col, upd_mr;
  logic [BANK_W-1:0] bank_next;
  logic [ROW_W-1:0]  row_next;
  logic [COL_W:0]    col_ap_next;
  logic [2*MR_W-1:0] mr_next;

  ddr_ca_rise_cap u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ca_i   (ca_i),
    .rise_o (rise_q)
  );

  ddr_ca_classify u_cls (
    .rise_i     (rise_q),
    .fall_i     (ca_i),
    .cmd_o      (cmd_next),
    .upd_bank_o (upd_bank),
    .upd_row_o  (upd_row),
    .upd_col_o  (upd_col),
    .upd_mr_o   (upd_mr),
    .bank_o     (bank_next),
    .row_o      (row_next),
    .col_ap_o   (col_ap_next),
    .mr_o       (mr_next)
  );

  ddr_ca_field_reg #(.W(CMD_W)) u_cmd_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1), .d_i(cmd_next), .q_o(cmd_o));

  ddr_ca_field_reg #(.W(BANK_W)) u_bank_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(upd_bank), .d_i(bank_next), .q_o(bank_o));

  ddr_ca_field_reg #(.W(ROW_W)) u_row_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(upd_row), .d_i(row_next), .q_o(row_o));

  ddr_ca_field_reg #(.W(COL_W+1)) u_col_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(upd_col), .d_i(col_ap_next), .q_o({col_o, ap_o}));

  ddr_ca_field_reg #(.W(2*MR_W)) u_mr_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(upd_mr), .d_i(mr_next),
    .q_o({mr_addr_o, mr_data_o}));
endmodule

// File: rtl/ddr_ca_decoder_chk.sv
`timescale 1ns/1ps
module ddr_ca_decoder_chk
  import ddr_ca_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CMD_W-1:0]  cmd_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [ROW_W-1:0]  row_o,
  input logic [COL_W-1:0]  col_o,
  input logic              ap_o,
  input logic [MR_W-1:0]   mr_addr_o,
  input logic [MR_W-1:0]   mr_data_o,
  input logic [CMD_W-1:0]  cmd_next,
  input logic              upd_bank,
  input logic              upd_row,
  input logic              upd_col,
  input logic              upd_mr
);
  // R1
  reset_clear_chk: assert property (@(negedge clk_i)
    !rst_ni |-> (cmd_o == '0 && bank_o == '0 && row_o == '0 && col_o == '0 &&
                 !ap_o && mr_addr_o == '0 && mr_data_o == '0));

  // R2
  cmd_follow_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cmd_o == $past(cmd_next));

  // R5
  bank_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !upd_bank |=> $stable(bank_o));

  // R6
  row_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !upd_row |=> $stable(row_o));

  // R7
  col_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !upd_col |=> ($stable(col_o) && $stable(ap_o)));

  // R8
  mr_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !upd_mr |=> ($stable(mr_addr_o) && $stable(mr_data_o)));

  // R9
  upd_excl_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $onehot0({upd_row, upd_col, upd_mr}));
endmodule

bind ddr_ca_decoder ddr_ca_decoder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_o     (cmd_o),
  .bank_o    (bank_o),
  .row_o     (row_o),
  .col_o     (col_o),
  .ap_o      (ap_o),
  .mr_addr_o (mr_addr_o),
  .mr_data_o (mr_data_o),
  .cmd_next  (cmd_next),
  .upd_bank  (upd_bank),
  .upd_row   (upd_row),
  .upd_col   (upd_col),
  .upd_mr    (upd_mr)
);

// File: tb/ddr_ca_decoder_test.sv
`timescale 1ns/1ps
module ddr_ca_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  ca = '1;
  logic [3:0]  cmd;
  logic [2:0]  bank;
  logic [14:0] row;
  logic [11:0] col;
  logic        ap;
  logic [7:0]  mra, mrd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_cmd = 0, m_bank = 0, m_row = 0, m_col = 0, m_ap = 0, m_mra = 0, m_mrd = 0;

  always #2.5 clk = ~clk;

  ddr_ca_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .ca_i(ca), .cmd_o(cmd), .bank_o(bank),
    .row_o(row), .col_o(col), .ap_o(ap), .mr_addr_o(mra), .mr_data_o(mrd));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    string creq;
    creq = (m_cmd >= 6) ? "R4" : "R3";
    chk(creq,  {tag, " cmd"},  int'(cmd),  m_cmd);
    chk("R5",  {tag, " bank"}, int'(bank), m_bank);
    chk("R6",  {tag, " row"},  int'(row),  m_row);
    chk("R7",  {tag, " col"},  int'(col),  m_col);
    chk("R7",  {tag, " ap"},   int'(ap),   m_ap);
    chk("R8",  {tag, " mra"},  int'(mra),  m_mra);
    chk("R8",  {tag, " mrd"},  int'(mrd),  m_mrd);
  endtask

  // Behavioural reference written with integer arithmetic.
  task automatic model(input int r, input int f);
    int b0, b1, b2, b3;
    b0 = r % 2; b1 = (r / 2) % 2; b2 = (r / 4) % 2; b3 = (r / 8) % 2;
    if (b0 == 0 && b1 == 0)      m_cmd = 6 + b2 + 2 * b3;
    else if (b0 == 0)            m_cmd = 1;
    else if (b1 == 0)            m_cmd = 2 + b2;
    else if (b2 == 0)            m_cmd = b3 ? 4 : 5;
    else                         m_cmd = 0;
    if (m_cmd >= 1 && m_cmd <= 4) m_bank = r / 128;
    if (m_cmd == 1) m_row = f * 32 + (r / 4) % 32;
    if (m_cmd == 2 || m_cmd == 3) begin
      m_col = (f / 2) * 8 + (r / 16) % 8;
      m_ap  = f % 2;
    end
    if (m_cmd == 6 || m_cmd == 7) begin
      m_mra = (r / 16) * 4 + f % 4;
      m_mrd = f / 4;
    end
  endtask

  // Entered about 1 ns after a falling edge; leaves at the same point one cycle later.
  task automatic drive(input int r, input int f, input string tag);
    ca = 10'(r);
    @(posedge clk);
    #0.5 ca = 10'(f);
    #1;
    // R2: falling half on the bus, falling edge not yet reached
    chk("R2", {tag, " before falling edge"}, int'(cmd), m_cmd);
    chk("R2", {tag, " row before falling edge"}, int'(row), m_row);
    @(negedge clk);
    #1;
    model(r, f);
    compare_all(tag);
  endtask

  task automatic reset_model();
    m_cmd = 0; m_bank = 0; m_row = 0; m_col = 0; m_ap = 0; m_mra = 0; m_mrd = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_up();
  end

  initial begin
    // R1: reset state
    #1;
    compare_all("R1 reset");
    @(negedge clk);
    @(negedge clk);
    #1 rst_n = 1'b1;

    // R1: first cycle after reset with NOP on the bus
    drive(10'h3FF, 10'h3FF, "nop");

    // R3 / R5 / R6: activate, bank 5, mixed row
    drive((5 << 7) | (13 << 2) | 2'b10, 10'h2A5, "R6 act");
    // R7: write with auto-precharge, bank 3
    drive((3 << 7) | (6 << 4) | 4'b0001, 10'h155, "R7 wr");
    // R7: read without auto-precharge
    drive((7 << 7) | (1 << 4) | 4'b0101, 10'h2AA, "R7 rd");
    // R3 / R5: precharge bank 2
    drive((2 << 7) | 4'b1011, 10'h0F0, "R5 pre");
    // R9: burst terminate leaves fields
    drive((6 << 7) | 4'b0011, 10'h3FF, "R9 bst");
    // R4 / R8: mode-register write
    drive((6'h2B << 4) | 4'b0000, 10'h1C6, "R8 mrw");
    // R4 / R8: mode-register read
    drive((6'h15 << 4) | 4'b0100, 10'h3FD, "R8 mrr");
    // R4 / R9: refresh per bank, then all banks
    drive((4 << 7) | 4'b1000, 10'h3FF, "R9 refpb");
    drive((1 << 7) | 4'b1100, 10'h000, "R9 refab");
    // R6 boundary: all-ones row, bank 7
    drive(10'h3FE, 10'h3FF, "R6 act max");
    // R7 boundary: all-zero column on bank 0
    drive(10'h001, 10'h000, "R7 wr zero");
    // R9: NOP with busy falling half
    drive(10'h3F7, 10'h2DB, "R9 nop");

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r, f;
      r = int'($urandom_range(0, 1023));
      f = int'($urandom_range(0, 1023));
      drive(r, f, "mix");
    end

    // R1: asynchronous reset between edges
    ca = 10'h00E;
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    reset_model();
    compare_all("R1 async");
    @(negedge clk);
    #1 rst_n = 1'b1;
    drive(10'h3FF, 10'h3FF, "R1 after");
    drive((1 << 7) | (2 << 2) | 2'b10, 10'h001, "R6 after reset");

    finish_up();
  end
endmodule